// File: doc/BRIEF.md
# Register Scoreboard Interlock

This block decides whether the instruction sitting in the decode stage of an in-order pipeline may move on. It keeps one ready bit for every architectural register. A register's bit drops when an instruction that will write it leaves decode. The bit rises again when the write-back stage reports that the register has been written.

Decode presents two source indices and one destination index. Each source has a use flag, and the destination has a write flag. The block raises `stall` if any operand it must check names a register whose ready bit is low. It does not try to tell read-after-write, write-after-write and write-after-read cases apart. It needs no comparators against the later pipeline stages.

The pipeline raises `advance` when the decoded instruction actually moves on. The destination bit is claimed only when `advance` is high and `stall` is low. A write-back reported in a cycle counts toward that same cycle's decode check. The current ready bits leave the block on `ready_vec`.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset, every bit of `ready_vec` is 1 and `stall` is 0 while no operand is in use.
- R2: If `advance` is 1, `stall` is 0 and `dst_wr` is 1, `ready_vec[dst_idx]` is 0 from the next cycle on, for any nonzero `dst_idx`.
- R3: `stall` is 1 in the same cycle when a source whose use flag is 1 names a register whose ready bit is 0 and that register gets no write-back in that cycle.
- R4: `stall` is 1 when `dst_wr` is 1 and the destination's ready bit is 0 with no write-back to it in that cycle. This covers a pending writer on a register the new instruction also targets.
- R5: A source whose use flag is 0, or a destination with `dst_wr` at 0, never causes `stall`.
- R6: With `wb_en` at 1, `ready_vec[wb_idx]` is 1 from the next cycle on. In the same cycle, that register already counts as ready for the stall decision.
- R7: If a write-back and a new claim by an advancing writer target the same register in one cycle, the register's bit is 0 in the next cycle.
- R8: When `stall` is 1 or `advance` is 0, no ready bit falls in the next cycle.
- R9: Register 0 always reads as ready and never causes `stall`, even when it is named as a destination.
- R10: `stall` is 1 to hold the instruction and 0 to let it proceed. It depends only on the current inputs and ready bits, not on `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | IDXW | First source register index |
| src_a_use | input | 1 | First source is read |
| src_b_idx | input | IDXW | Second source register index |
| src_b_use | input | 1 | Second source is read |
| dst_idx | input | IDXW | Destination register index |
| dst_wr | input | 1 | Instruction writes its destination |
| advance | input | 1 | Decoded instruction leaves decode this cycle |
| wb_idx | input | IDXW | Register completed by write-back |
| wb_en | input | 1 | Write-back completes this cycle |
| stall | output | 1 | 1 holds decode, 0 proceeds |
| ready_vec | output | NREGS | Current ready bit of every register |

## Verification
The hardest situation to reach from the ports is a single cycle where a write-back and an advancing writer hit the same register. The same register must also have been claimed earlier, so that the same-cycle bypass is the only thing keeping `stall` low. The stimulus first claims the register. It then presents, in one cycle, a write-back to that register together with a new writer of it. The check is that `stall` stays low in that cycle and the bit reads 0 on the next one. A stalled writer with `advance` held high is also driven, to show that a held instruction claims nothing.

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NREGS = 32,
  parameter int IDXW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  src_a_idx,
  input  logic             src_a_use,
  input  logic [IDXW-1:0]  src_b_idx,
  input  logic             src_b_use,
  input  logic [IDXW-1:0]  dst_idx,
  input  logic             dst_wr,
  input  logic             advance,
  input  logic [IDXW-1:0]  wb_idx,
  input  logic             wb_en,
  output logic             stall,
  output logic [NREGS-1:0] ready_vec
);

  localparam logic [NREGS-1:0] ONE  = NREGS'(1);
  localparam logic [NREGS-1:0] ZERO_MASK = ~ONE;

  logic [NREGS-1:0] rdy_q;
  logic [NREGS-1:0] set_vec;
  logic [NREGS-1:0] clr_vec;
  logic [NREGS-1:0] eff_rdy;
  logic             hit_a, hit_b, hit_d, claim;

  assign set_vec = wb_en ? (ONE << wb_idx) : '0;
  assign eff_rdy = rdy_q | set_vec | ONE;

  assign hit_a = src_a_use & ~eff_rdy[src_a_idx];
  assign hit_b = src_b_use & ~eff_rdy[src_b_idx];
  assign hit_d = dst_wr    & ~eff_rdy[dst_idx];
  assign stall = hit_a | hit_b | hit_d;

  assign claim   = advance & ~stall & dst_wr;
  assign clr_vec = claim ? ((ONE << dst_idx) & ZERO_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= '1;
    else        rdy_q <= ((rdy_q | set_vec) & ~clr_vec) | ONE;
  end

  assign ready_vec = rdy_q;

endmodule

// File: rtl/reg_scoreboard_chk.sv
module reg_scoreboard_chk #(
  parameter int NREGS = 32,
  parameter int IDXW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDXW-1:0]  src_a_idx,
  input logic             src_a_use,
  input logic [IDXW-1:0]  src_b_idx,
  input logic             src_b_use,
  input logic [IDXW-1:0]  dst_idx,
  input logic             dst_wr,
  input logic             advance,
  input logic [IDXW-1:0]  wb_idx,
  input logic             wb_en,
  input logic             stall,
  input logic [NREGS-1:0] ready_vec
);

  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stall && dst_wr && dst_idx != '0) |=> !ready_vec[$past(dst_idx)]);

  p_src_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_use && !ready_vec[src_a_idx] && !(wb_en && wb_idx == src_a_idx)) |-> stall);

  p_src_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_use && !ready_vec[src_b_idx] && !(wb_en && wb_idx == src_b_idx)) |-> stall);

  p_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr && !ready_vec[dst_idx] && !(wb_en && wb_idx == dst_idx)) |-> stall);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_a_use && !src_b_use && !dst_wr) |-> !stall);

  p_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(advance && !stall && dst_wr && dst_idx == wb_idx)) |=> ready_vec[$past(wb_idx)]);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && advance && !stall && dst_wr && dst_idx == wb_idx && wb_idx != '0)
      |=> !ready_vec[$past(wb_idx)]);

  p_no_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !advance || !dst_wr) |=> (($past(ready_vec) & ~ready_vec) == '0));

  p_reg0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_vec[0]);

endmodule

bind reg_scoreboard reg_scoreboard_chk #(.NREGS(NREGS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .src_a_idx(src_a_idx), .src_a_use(src_a_use),
  .src_b_idx(src_b_idx), .src_b_use(src_b_use),
  .dst_idx(dst_idx), .dst_wr(dst_wr), .advance(advance),
  .wb_idx(wb_idx), .wb_en(wb_en),
  .stall(stall), .ready_vec(ready_vec)
);

// File: tb/reg_scoreboard_tb.sv
module reg_scoreboard_tb;
  localparam int PERIOD = 10;
  localparam int NR = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] sa = '0, sb = '0, di = '0, wi = '0;
  logic sau = 0, sbu = 0, dw = 0, adv = 0, we = 0;
  logic stall;
  logic [NR-1:0] rdy;

  always #(PERIOD/2) clk = ~clk;

  reg_scoreboard #(.NREGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_a_idx(sa), .src_a_use(sau), .src_b_idx(sb), .src_b_use(sbu),
    .dst_idx(di), .dst_wr(dw), .advance(adv), .wb_idx(wi), .wb_en(we),
    .stall(stall), .ready_vec(rdy)
  );

  typedef struct {
    logic          st;
    logic [NR-1:0] rv;
    string         tag;
  } item_t;

  item_t q[$];
  logic [NR-1:0] model = '1;
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic drive(input int a, input bit au, input int b, input bit bu,
                       input int d, input bit dwr, input bit ad,
                       input int w, input bit wen, input string tag);
    logic [NR-1:0] eff, setv;
    logic es;
    item_t it;
    @(negedge clk);
    sa = IW'(a); sau = au; sb = IW'(b); sbu = bu;
    di = IW'(d); dw = dwr; adv = ad; wi = IW'(w); we = wen;
    setv = '0;
    if (wen) setv[w] = 1'b1;
    eff = model | setv;
    eff[0] = 1'b1;
    es = (au && !eff[a]) || (bu && !eff[b]) || (dwr && !eff[d]);
    it.st = es; it.rv = model; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    model = model | setv;
    if (ad && !es && dwr && d != 0) model[d] = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compared++;
        if (stall !== it.st || rdy !== it.rv) begin
          mismatched++;
          $display("FAIL %s: stall=%0b ready=%h expected stall=%0b ready=%h",
                   it.tag, stall, rdy, it.st, it.rv);
        end
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0,0,0,0,0,0,0,0,0, "R1 reset state");
    drive(0,0,0,0,5,1,1,0,0, "R2 claim r5");
    drive(0,0,0,0,0,0,0,0,0, "R2 r5 now pending");
    drive(5,1,2,1,0,0,1,0,0, "R3 RAW on source a");
    drive(2,1,5,1,0,0,1,0,0, "R3 RAW on source b");
    drive(5,0,5,0,6,1,0,0,0, "R5 unused sources ignored");
    drive(1,1,2,1,5,1,1,0,0, "R4 WAW on pending destination");
    drive(5,1,0,0,7,1,1,0,0, "R8 stalled writer claims nothing");
    drive(0,0,0,0,9,1,0,0,0, "R8 no advance claims nothing");
    drive(0,0,0,0,0,0,0,0,0, "R8 r7 r9 still ready");
    drive(5,1,5,1,5,1,0,5,1, "R6 same-cycle write-back bypass");
    drive(5,1,0,0,0,0,0,0,0, "R6 r5 ready after write-back");
    drive(0,0,0,0,3,1,1,0,0, "R2 claim r3");
    drive(3,1,0,0,3,1,1,3,1, "R7 set and clear same cycle");
    drive(3,1,0,0,0,0,0,0,0, "R7 clear wins");
    drive(0,1,0,1,0,1,1,0,0, "R9 register 0 as source and destination");
    drive(0,0,0,0,0,0,0,0,0, "R9 register 0 still ready");
    drive(3,1,0,0,0,0,0,0,0, "R10 stall independent of advance low");
    drive(3,1,0,0,0,0,1,0,0, "R10 stall independent of advance high");
    drive(0,0,0,0,0,0,0,3,1, "R6 release r3");
    drive(3,1,3,1,3,1,0,0,0, "R6 r3 ready after release");
    repeat (2) @(negedge clk);
    #5;
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL monitor: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule